// File: doc/BRIEF.md
# Clock-Synthesizer Watchdog with Frequency Recovery

This block guards the frequency-control path of a clock synthesizer. Software arms a watchdog through a small byte-wide register port. It picks a multiplier from 1 to 7 and one of two time bases; the time bases are derived from a free-running reference tick. If software does not service the watchdog before the count runs out, the block does three things. It sets a sticky alarm flag. It emits one fixed-width system reset pulse. Depending on a mode bit, it also forces the active frequency setting back to a safe value.

The block also holds the frequency selector. The output select code comes from the hardware-latched strap code or from a software code, chosen by an override bit. A programmed-divider enable passes stored N and M divider values on to the synthesizer. On a recovering timeout, a recovery-select bit chooses the fallback. One choice reverts to the straps by clearing the override and the divider enable. The other forces the stored programmed divider into use.

Register map, byte-wide, selected by `reg_addr_i`. Address 0 is the watchdog control register. Address 1 is the frequency control register. Address 2 holds divider N. Address 3 holds divider M, in bits 6:0.

Top module: `wdt_freq_recovery`

## Requirements
- R1: After reset all registers read 0, `sys_rst_o` is low, `cpu_prog_o` is low and `fsel_o` equals `hw_fsel_i`.
- R2: Frequency control register: bits 3:0 hold the software select code, bit 4 is the override and bit 5 is the programmed-divider enable. `fsel_o` is the software code when the override is 1 and `hw_fsel_i` when it is 0. `cpu_prog_o`, `cpu_n_o` and `cpu_m_o` follow the stored values.
- R3: Watchdog control register: bit 0 is enable, bits 3:1 are the multiplier, bit 5 is the scale, bit 6 is the mode, bit 7 is the recovery select, and bit 4 is the read-only alarm. A write with the enable bit set and a non-zero multiplier arms the watchdog. With scale 0, the timeout is multiplier × `BASE_LO` ticks, counted from the write edge.
- R4: With scale 1, the timeout is multiplier × `BASE_HI` ticks.
- R5: The count advances only on clock edges where `tick_i` is high.
- R6: The alarm bit becomes 1 in the cycle after expiry. It stays 1 until any write to address 0, and that write clears it.
- R7: Each expiry gives exactly one `sys_rst_o` pulse of `RST_W` cycles, starting on the expiry edge. The count then stops until software writes address 0 again.
- R8: A write to address 0 that arms the watchdog while it is already running restarts the full timeout (service).
- R9: A write to address 0 with the enable bit cleared stops the count. Multiplier 000 is a test mode that never times out.
- R10: On expiry with mode 0 and recovery select 0, the override and divider enable are cleared, so `fsel_o` returns to `hw_fsel_i` and `cpu_prog_o` goes low.
- R11: On expiry with mode 0 and recovery select 1, the divider enable is set. The override and select code are kept.
- R12: On expiry with mode 1, only the reset and alarm occur. The frequency registers are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Free-running reference tick, one-cycle strobes |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i` |
| hw_fsel_i | input | 4 | Hardware-latched strap select code |
| sys_rst_o | output | 1 | System reset pulse on timeout |
| fsel_o | output | 4 | Active frequency select code |
| cpu_prog_o | output | 1 | Programmed divider in use |
| cpu_n_o | output | 8 | Programmed divider N |
| cpu_m_o | output | 7 | Programmed divider M |

## Verification
A wrong internal count shows at the ports as an alarm and reset pulse one or more cycles early or late. The bench therefore samples the alarm bit one cycle before and exactly on the computed expiry edge for each scale, service, paused-tick and disable case. A stuck or duplicated reset counter shows as a pulse of the wrong width, or as a second pulse while the alarm is still standing. A wrong recovery decision shows in the very next cycle, on `fsel_o` and `cpu_prog_o`, for each mode and recovery-select combination.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
  localparam int REG_W  = 8;
  localparam int FSEL_W = 4;
  localparam int MULT_W = 3;
  localparam int N_W    = 8;
  localparam int M_W    = 7;

  typedef enum logic [1:0] {
    ADDR_WDOG = 2'd0,
    ADDR_FREQ = 2'd1,
    ADDR_DIVN = 2'd2,
    ADDR_DIVM = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic              rec_sel;
    logic              mode;
    logic              scale;
    logic [MULT_W-1:0] mult;
    logic              en;
  } wdog_ctrl_t;

  typedef struct packed {
    logic              prog_en;
    logic              override;
    logic [FSEL_W-1:0] sw_fsel;
  } freq_ctrl_t;
endpackage

// File: rtl/wdt_prescaler.sv
`timescale 1ns/1ps
module wdt_prescaler #(
  parameter int BASE_LO = 8,
  parameter int BASE_HI = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  input  logic tick_i,
  input  logic scale_i,
  output logic base_stb_o
);
  localparam int MAXB  = (BASE_HI > BASE_LO) ? BASE_HI : BASE_LO;
  localparam int CNT_W = $clog2(MAXB + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] top;

  assign top        = scale_i ? CNT_W'(BASE_HI - 1) : CNT_W'(BASE_LO - 1);
  assign base_stb_o = run_i && tick_i && (cnt_q == top);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clear_i || !run_i) cnt_q <= '0;
    else if (tick_i)            cnt_q <= (cnt_q == top) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdt_core.sv
`timescale 1ns/1ps
module wdt_core #(
  parameter int MULT_W = 3,
  parameter int RST_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              stop_i,
  input  logic [MULT_W-1:0] mult_i,
  input  logic              base_stb_i,
  output logic              run_o,
  output logic              expire_o,
  output logic              sys_rst_o
);
  localparam int RC_W = $clog2(RST_W + 1);

  logic              run_q;
  logic [MULT_W-1:0] unit_q;
  logic [RC_W-1:0]   rcnt_q;

  assign run_o     = run_q;
  assign expire_o  = run_q && base_stb_i && (unit_q == MULT_W'(1)) && !load_i && !stop_i;
  assign sys_rst_o = (rcnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      unit_q <= '0;
    end else if (load_i) begin
      run_q  <= 1'b1;
      unit_q <= mult_i;
    end else if (stop_i) begin
      run_q  <= 1'b0;
    end else if (run_q && base_stb_i) begin
      if (unit_q == MULT_W'(1)) run_q <= 1'b0;
      else                      unit_q <= unit_q - 1'b1;
    end
  end

  // one pulse per expiry
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rcnt_q <= '0;
    else if (expire_o)        rcnt_q <= RC_W'(RST_W);
    else if (rcnt_q != '0)    rcnt_q <= rcnt_q - 1'b1;
  end
endmodule

// File: rtl/wdt_freq_sel.sv
`timescale 1ns/1ps
module wdt_freq_sel
  import wdt_pkg::*;
(
  input  freq_ctrl_t        ctrl_i,
  input  logic [FSEL_W-1:0] hw_fsel_i,
  output logic [FSEL_W-1:0] fsel_o,
  output logic              cpu_prog_o
);
  assign fsel_o     = ctrl_i.override ? ctrl_i.sw_fsel : hw_fsel_i;
  assign cpu_prog_o = ctrl_i.prog_en;
endmodule

// File: rtl/wdt_freq_recovery.sv
`timescale 1ns/1ps
module wdt_freq_recovery
  import wdt_pkg::*;
#(
  parameter int BASE_LO = 8,
  parameter int BASE_HI = 20,
  parameter int RST_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic [FSEL_W-1:0] hw_fsel_i,
  output logic              sys_rst_o,
  output logic [FSEL_W-1:0] fsel_o,
  output logic              cpu_prog_o,
  output logic [N_W-1:0]    cpu_n_o,
  output logic [M_W-1:0]    cpu_m_o
);
  wdog_ctrl_t       wctl_q;
  freq_ctrl_t       fctl_q;
  logic             alarm_q;
  logic [N_W-1:0]   div_n_q;
  logic [M_W-1:0]   div_m_q;
  logic             wr_wdog, wr_freq, load, stop, run, base_stb, expire;
  wdog_ctrl_t       wctl_d;

  assign wr_wdog = reg_we_i && (reg_addr_i == ADDR_WDOG);
  assign wr_freq = reg_we_i && (reg_addr_i == ADDR_FREQ);
  assign wctl_d  = '{rec_sel: reg_wdata_i[7], mode: reg_wdata_i[6], scale: reg_wdata_i[5],
                     mult: reg_wdata_i[3:1], en: reg_wdata_i[0]};
  assign load    = wr_wdog && wctl_d.en && (wctl_d.mult != '0);
  assign stop    = wr_wdog && !load;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wctl_q  <= '0;
      alarm_q <= 1'b0;
      div_n_q <= '0;
      div_m_q <= '0;
    end else begin
      if (wr_wdog) begin
        wctl_q  <= wctl_d;
        alarm_q <= 1'b0;
      end else if (expire) begin
        alarm_q <= 1'b1;
      end
      if (reg_we_i && reg_addr_i == ADDR_DIVN) div_n_q <= reg_wdata_i;
      if (reg_we_i && reg_addr_i == ADDR_DIVM) div_m_q <= reg_wdata_i[M_W-1:0];
    end
  end

  // recovery takes priority over a same-cycle software write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fctl_q <= '0;
    end else if (expire && !wctl_q.mode) begin
      if (wctl_q.rec_sel) begin
        fctl_q.prog_en <= 1'b1;
      end else begin
        fctl_q.prog_en  <= 1'b0;
        fctl_q.override <= 1'b0;
      end
    end else if (wr_freq) begin
      fctl_q <= freq_ctrl_t'(reg_wdata_i[FSEL_W+1:0]);
    end
  end

  wdt_prescaler #(.BASE_LO(BASE_LO), .BASE_HI(BASE_HI)) u_pre (
    .clk_i, .rst_ni, .clear_i(load), .run_i(run), .tick_i,
    .scale_i(wctl_q.scale), .base_stb_o(base_stb)
  );

  wdt_core #(.MULT_W(MULT_W), .RST_W(RST_W)) u_core (
    .clk_i, .rst_ni, .load_i(load), .stop_i(stop), .mult_i(wctl_d.mult),
    .base_stb_i(base_stb), .run_o(run), .expire_o(expire), .sys_rst_o
  );

  wdt_freq_sel u_sel (
    .ctrl_i(fctl_q), .hw_fsel_i, .fsel_o, .cpu_prog_o
  );

  assign cpu_n_o = div_n_q;
  assign cpu_m_o = div_m_q;

  always_comb begin
    unique case (reg_addr_i)
      ADDR_WDOG: reg_rdata_o = {wctl_q.rec_sel, wctl_q.mode, wctl_q.scale, alarm_q,
                                wctl_q.mult, wctl_q.en};
      ADDR_FREQ: reg_rdata_o = {2'b00, fctl_q};
      ADDR_DIVN: reg_rdata_o = div_n_q;
      default:   reg_rdata_o = {1'b0, div_m_q};
    endcase
  end
endmodule

// File: rtl/wdt_freq_recovery_chk.sv
`timescale 1ns/1ps
module wdt_freq_recovery_chk
  import wdt_pkg::*;
#(
  parameter int RST_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [1:0]        reg_addr_i,
  input logic              alarm,
  input logic              mode,
  input logic              rec_sel,
  input logic [MULT_W-1:0] mult,
  input logic              sys_rst_o,
  input logic [FSEL_W-1:0] fsel_o,
  input logic [FSEL_W-1:0] hw_fsel_i,
  input logic              cpu_prog_o
);
  logic [15:0] hi_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hi_cnt <= '0;
    else if (sys_rst_o) hi_cnt <= hi_cnt + 1'b1;
    else                hi_cnt <= '0;
  end

  assert_alarm_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm && !(reg_we_i && reg_addr_i == 2'd0)) |=> alarm);

  assert_rst_with_alarm_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_o) |-> $rose(alarm));

  assert_rst_width_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_o) |-> (hi_cnt == 16'(RST_W)));

  assert_test_mode_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alarm) |-> ($past(mult) != '0));

  assert_recover_hw_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(alarm) && !$past(mode) && !$past(rec_sel)) |-> (fsel_o == hw_fsel_i && !cpu_prog_o));

  assert_recover_prog_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(alarm) && !$past(mode) && $past(rec_sel)) |-> cpu_prog_o);

  assert_reset_only_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(alarm) && $past(mode) && !$past(reg_we_i)) |-> ($stable(fsel_o) && $stable(cpu_prog_o)));
endmodule

bind wdt_freq_recovery wdt_freq_recovery_chk #(.RST_W(RST_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .alarm(alarm_q), .mode(wctl_q.mode), .rec_sel(wctl_q.rec_sel), .mult(wctl_q.mult),
  .sys_rst_o(sys_rst_o), .fsel_o(fsel_o), .hw_fsel_i(hw_fsel_i), .cpu_prog_o(cpu_prog_o)
);

// File: tb/wdt_freq_recovery_tb.sv
`timescale 1ns/1ps
module wdt_freq_recovery_tb;
  localparam int BASE_LO = 8;
  localparam int BASE_HI = 20;
  localparam int RST_W   = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [3:0] hw_fsel = 4'h5;
  logic       sys_rst;
  logic [3:0] fsel;
  logic       cpu_prog;
  logic [7:0] cpu_n;
  logic [6:0] cpu_m;

  always #4 clk = ~clk;

  wdt_freq_recovery #(.BASE_LO(BASE_LO), .BASE_HI(BASE_HI), .RST_W(RST_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .hw_fsel_i(hw_fsel), .sys_rst_o(sys_rst),
    .fsel_o(fsel), .cpu_prog_o(cpu_prog), .cpu_n_o(cpu_n), .cpu_m_o(cpu_m)
  );

  typedef enum int {OBS_RST, OBS_ALARM, OBS_FSEL, OBS_PROG, OBS_N, OBS_M, OBS_RDATA} obs_e;
  typedef struct {
    string req;
    obs_e  sel;
    int    exp;
  } item_t;

  item_t q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  function automatic int observe(obs_e s);
    case (s)
      OBS_RST:   return int'(sys_rst);
      OBS_ALARM: return int'(rdata[4]);
      OBS_FSEL:  return int'(fsel);
      OBS_PROG:  return int'(cpu_prog);
      OBS_N:     return int'(cpu_n);
      OBS_M:     return int'(cpu_m);
      default:   return int'(rdata);
    endcase
  endfunction

  // driver side: push expectation for the current cycle
  task automatic expect_val(string req, obs_e sel, int exp);
    item_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    q.push_back(it);
  endtask

  // monitor: compare just after the falling edge
  always @(negedge clk) begin
    #1;
    while (q.size() > 0) begin
      item_t it;
      int act;
      it = q.pop_front();
      act = observe(it.sel);
      n_chk++;
      if (act != it.exp) begin
        n_fail++;
        $display("FAIL %s %s: actual %0h expected %0h", it.req, it.sel.name(), act, it.exp);
      end
    end
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0; addr = 2'd0; wdata = 8'h00;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    cycles(3);
    rst_n = 1'b1;
    cycles(1);
    // R1 reset state
    expect_val("R1", OBS_RDATA, 0);
    expect_val("R1", OBS_RST, 0);
    expect_val("R1", OBS_FSEL, 5);
    expect_val("R1", OBS_PROG, 0);

    // R2 selector paths
    wr(2'd1, 8'h1A);
    expect_val("R2", OBS_FSEL, 'hA);
    wr(2'd2, 8'h37);
    wr(2'd3, 8'h92);
    expect_val("R2", OBS_N, 'h37);
    expect_val("R2", OBS_M, 'h12);
    wr(2'd1, 8'h2A);
    expect_val("R2", OBS_FSEL, 5);
    expect_val("R2", OBS_PROG, 1);
    wr(2'd1, 8'h1A);

    // R3/R7/R12: mult 2, scale 0, reset-only mode -> 16 ticks
    wr(2'd0, 8'h45);
    cycles(15);
    expect_val("R3", OBS_ALARM, 0);
    expect_val("R3", OBS_RST, 0);
    cycles(1);
    expect_val("R3", OBS_ALARM, 1);
    expect_val("R7", OBS_RST, 1);
    expect_val("R12", OBS_FSEL, 'hA);
    expect_val("R12", OBS_PROG, 0);
    cycles(3);
    expect_val("R7", OBS_RST, 1);
    cycles(1);
    expect_val("R7", OBS_RST, 0);
    cycles(40);
    expect_val("R6", OBS_ALARM, 1);
    expect_val("R7", OBS_RST, 0);

    // R6 clear, R8 service, R10 recovery to straps
    wr(2'd0, 8'h03);
    expect_val("R6", OBS_ALARM, 0);
    cycles(5);
    wr(2'd0, 8'h03);
    cycles(7);
    expect_val("R8", OBS_ALARM, 0);
    cycles(1);
    expect_val("R8", OBS_ALARM, 1);
    expect_val("R10", OBS_FSEL, 5);
    expect_val("R10", OBS_PROG, 0);

    // R4 long base, R11 recovery to programmed divider
    wr(2'd1, 8'h1A);
    wr(2'd0, 8'hA3);
    cycles(19);
    expect_val("R4", OBS_ALARM, 0);
    expect_val("R11", OBS_PROG, 0);
    cycles(1);
    expect_val("R4", OBS_ALARM, 1);
    expect_val("R11", OBS_PROG, 1);
    expect_val("R11", OBS_FSEL, 'hA);

    // R9 test-mode multiplier
    wr(2'd0, 8'h01);
    expect_val("R6", OBS_ALARM, 0);
    cycles(300);
    expect_val("R9", OBS_ALARM, 0);
    expect_val("R9", OBS_RST, 0);

    // R9 disable before expiry
    wr(2'd0, 8'h03);
    cycles(4);
    wr(2'd0, 8'h02);
    cycles(20);
    expect_val("R9", OBS_ALARM, 0);
    expect_val("R9", OBS_RST, 0);

    // R5 tick gating
    tick = 1'b0;
    wr(2'd0, 8'h03);
    cycles(50);
    expect_val("R5", OBS_ALARM, 0);
    tick = 1'b1;
    cycles(7);
    expect_val("R5", OBS_ALARM, 0);
    cycles(1);
    expect_val("R5", OBS_ALARM, 1);

    cycles(3);
    done = 1'b1;
    finish_run();
  end
endmodule